// File: doc/BRIEF.md
# Video Display Processor Bus Glue

This block sits between an 8-bit CPU bus with a two-phase clock and a video display processor that has two ports. It decodes the CPU address so that the display processor answers at a pair of adjacent addresses. It turns each decoded access into an active-low read or write strobe, and a strobe is issued only while the CPU's Phi2 phase is high. The R/W line picks which strobe is issued. CPU address bit 0 becomes the processor's port-select line.

The display processor counts its data pins from the most significant end. For this reason the block reverses the bit order in both directions: CPU write data goes to the device reversed, and device read data comes back to the CPU reversed. Read data reaches the CPU bus only while a read strobe is active. At all other times the CPU-side output enable stays low.

The glue runs on a fast system clock that oversamples the CPU bus. It registers the strobes, the port-select line and the write data once per clock, so each of these outputs follows its inputs one clock later. The reset is synchronous and active-low.

Top module: `vdp_bus_glue`

## Requirements
- R1: While `rst_n` is low at a clock edge, both strobes go high (inactive), `dev_mode` goes to 0, `dev_wdata` goes to 0 and `cpu_rdata_oe` goes to 0.
- R2: An access is decoded when `cpu_addr[15:1]` equals `BASE_ADDR[15:1]`, with default base 16'hC000. This selects exactly the two addresses 16'hC000 and 16'hC001. Any other address produces no strobe.
- R3: One clock after a sample with a decoded address, `cpu_phi2`=1 and `cpu_rw`=1, `dev_rd_n` is 0 and `dev_wr_n` is 1.
- R4: One clock after a sample with a decoded address, `cpu_phi2`=1 and `cpu_rw`=0, `dev_wr_n` is 0 and `dev_rd_n` is 1.
- R5: One clock after a sample with `cpu_phi2`=0, both strobes are 1, whatever the address and R/W.
- R6: `dev_rd_n` and `dev_wr_n` are never both 0.
- R7: `dev_mode` equals the value `cpu_addr[0]` had at the previous clock edge, whether or not the address decodes.
- R8: While `dev_wr_n` is 0, `dev_wdata[i]` equals bit 7-i of the `cpu_wdata` sampled one clock earlier. While `dev_wr_n` is 1, `dev_wdata` is 0.
- R9: `cpu_rdata_oe` is 1 exactly while `dev_rd_n` is 0. In that window `cpu_rdata[i]` equals `dev_rdata[7-i]` and follows `dev_rdata` in the same cycle. Outside that window `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the CPU bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU R/W line, 1 = read |
| cpu_phi2 | input | 1 | CPU Phi2 phase, 1 during the data phase |
| cpu_wdata | input | 8 | Data the CPU drives on a write |
| cpu_rdata | output | 8 | Bit-reversed device data for the CPU bus |
| cpu_rdata_oe | output | 1 | Output enable for `cpu_rdata` onto the CPU bus |
| dev_rd_n | output | 1 | Active-low read strobe to the display processor |
| dev_wr_n | output | 1 | Active-low write strobe to the display processor |
| dev_mode | output | 1 | Port select to the display processor |
| dev_wdata | output | 8 | Bit-reversed write data to the display processor |
| dev_rdata | input | 8 | Data the display processor drives on a read |

## Verification
The bench drives both decoded addresses with each R/W value while Phi2 is high. This separates the read strobe from the write strobe, and it shows that bit 0 reaches the port-select line. The same decoded accesses are then repeated with Phi2 low, to confirm that the phase gates the strobes on its own. Near-miss addresses are also driven: the next pair up, the address just below the base, and one with only the top bit changed. These show that the decode compares every upper bit and ignores bit 0. Asymmetric data values such as 8'h01, 8'hC5 and 8'h12 are used, so that a missing or partial reversal gives a different byte in each direction. The read data is also changed during an active read, to confirm that the read path passes data through in the same cycle.

// File: rtl/vdp_glue_pkg.sv
// Package: shared types for the display-processor bus glue.
// Assumes: nothing beyond IEEE 1800-2017.
package vdp_glue_pkg;

    // Kind of device access decided for one sample of the CPU bus
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/vdp_addr_match.sv
// Module: vdp_addr_match
// Decides whether a CPU address falls in the two-address window of the device.
// Assumes: BASE_ADDR bit 0 carries no meaning; the window is BASE and BASE^1.
module vdp_addr_match #(
    parameter int                  ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]   BASE_ADDR = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              port_sel
);

    localparam logic [ADDR_W-2:0] PAIR_TAG = BASE_ADDR[ADDR_W-1:1];

    // Compare the upper address bits against the pair tag, pass bit 0 out
    always_comb begin
        hit      = (addr[ADDR_W-1:1] == PAIR_TAG);
        port_sel = addr[0];
    end

endmodule

// File: rtl/vdp_bit_reverse.sv
// Module: vdp_bit_reverse
// Mirrors bit significance of a bus: output bit i takes input bit W-1-i.
// Assumes: purely combinational, any width of at least one.
module vdp_bit_reverse #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // One wire per bit, crossing to the mirrored position
    for (genvar gi = 0; gi < W; gi++) begin : g_swap
        assign dout[gi] = din[W-1-gi];
    end

endmodule

// File: rtl/vdp_strobe_gen.sv
// Module: vdp_strobe_gen
// Turns a decoded bus sample into registered active-low read/write strobes.
// Assumes: phi2 and rw are sampled by clk, which is much faster than Phi2.
module vdp_strobe_gen
    import vdp_glue_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      phi2,
    input  logic      rw,
    output acc_kind_e acc_now,
    output logic      rd_n,
    output logic      wr_n
);

    // Classify the current sample: no strobe unless decoded during Phi2
    always_comb begin
        if (hit && phi2) acc_now = rw ? ACC_READ : ACC_WRITE;
        else             acc_now = ACC_IDLE;
    end

    // Register the strobes; reset parks both inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
        end else begin
            rd_n <= (acc_now != ACC_READ);
            wr_n <= (acc_now != ACC_WRITE);
        end
    end

endmodule

// File: rtl/vdp_bus_glue.sv
// Module: vdp_bus_glue (top)
// Maps a two-port video display processor into CPU address space: decodes
// the pair of addresses, issues Phi2-gated strobes, drives the port select
// from address bit 0 and reverses data bit order in both directions.
// Assumes: clk oversamples the CPU bus; the device numbers its data pins
// from the most significant end.
module vdp_bus_glue
    import vdp_glue_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_phi2,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdata_oe,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic              dev_mode,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);

    logic              hit;
    logic              port_sel;
    acc_kind_e         acc_now;
    logic [DATA_W-1:0] wdata_rev;
    logic [DATA_W-1:0] rdata_rev;

    vdp_addr_match #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_match (
        .addr     (cpu_addr),
        .hit      (hit),
        .port_sel (port_sel)
    );

    vdp_strobe_gen u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .phi2    (cpu_phi2),
        .rw      (cpu_rw),
        .acc_now (acc_now),
        .rd_n    (dev_rd_n),
        .wr_n    (dev_wr_n)
    );

    vdp_bit_reverse #(.W(DATA_W)) u_rev_wr (
        .din  (cpu_wdata),
        .dout (wdata_rev)
    );

    vdp_bit_reverse #(.W(DATA_W)) u_rev_rd (
        .din  (dev_rdata),
        .dout (rdata_rev)
    );

    // Register port select and write data alongside the strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_mode  <= 1'b0;
            dev_wdata <= '0;
        end else begin
            dev_mode  <= port_sel;
            dev_wdata <= (acc_now == ACC_WRITE) ? wdata_rev : '0;
        end
    end

    // Drive the CPU bus only while the read strobe is active
    always_comb begin
        cpu_rdata_oe = !dev_rd_n;
        cpu_rdata    = dev_rd_n ? '0 : rdata_rev;
    end

endmodule

// File: rtl/vdp_bus_glue_chk.sv
// Module: vdp_bus_glue_chk
// Checker bound to vdp_bus_glue; relates outputs to the inputs one clock back.
// Assumes: properties are meaningful only once a non-reset edge has passed.
module vdp_bus_glue_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              cpu_phi2,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_rdata_oe,
    input logic              dev_rd_n,
    input logic              dev_wr_n,
    input logic              dev_mode,
    input logic [DATA_W-1:0] dev_wdata,
    input logic [DATA_W-1:0] dev_rdata
);

    logic primed;
    logic sel;

    // Set once the previous edge was taken out of reset
    always_ff @(posedge clk) begin
        primed <= rst_n;
    end

    // Checker's own view of the address window
    always_comb sel = (cpu_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n));

    // R3
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $past(sel && cpu_phi2 && cpu_rw) |-> (!dev_rd_n && dev_wr_n));

    // R4
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $past(sel && cpu_phi2 && !cpu_rw) |-> (!dev_wr_n && dev_rd_n));

    // R5
    phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $past(!cpu_phi2 || !sel) |-> (dev_rd_n && dev_wr_n));

    // R7
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        dev_mode == $past(cpu_addr[0]));

    // R8
    wdata_rev_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        !dev_wr_n |-> (dev_wdata[0] == $past(cpu_wdata[DATA_W-1])));

    // R9
    rdata_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdata_oe == !dev_rd_n) &&
        (cpu_rdata_oe ? (cpu_rdata[DATA_W-1] == dev_rdata[0]) : (cpu_rdata == '0)));

endmodule

bind vdp_bus_glue vdp_bus_glue_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_rw       (cpu_rw),
    .cpu_phi2     (cpu_phi2),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe),
    .dev_rd_n     (dev_rd_n),
    .dev_wr_n     (dev_wr_n),
    .dev_mode     (dev_mode),
    .dev_wdata    (dev_wdata),
    .dev_rdata    (dev_rdata)
);

// File: tb/vdp_bus_glue_tb.sv
// Bench for vdp_bus_glue: table-driven bus samples, then reset and corner tests.
module vdp_bus_glue_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_phi2 = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic        dev_rd_n;
    logic        dev_wr_n;
    logic        dev_mode;
    logic [7:0]  dev_wdata;
    logic [7:0]  dev_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vdp_bus_glue u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_rw       (cpu_rw),
        .cpu_phi2     (cpu_phi2),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_rdata_oe (cpu_rdata_oe),
        .dev_rd_n     (dev_rd_n),
        .dev_wr_n     (dev_wr_n),
        .dev_mode     (dev_mode),
        .dev_wdata    (dev_wdata),
        .dev_rdata    (dev_rdata)
    );

    // {addr, rw, phi2, wdata, dev_rdata, exp rd_n, wr_n, mode, oe, cpu_rdata, dev_wdata}
    localparam int NV = 11;
    localparam logic [53:0] VEC [NV] = '{
        {16'hC000, 1'b1, 1'b1, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 8'h00},
        {16'hC001, 1'b1, 1'b1, 8'h00, 8'hC5, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA3, 8'h00},
        {16'hC001, 1'b0, 1'b1, 8'h12, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h48},
        {16'hC000, 1'b0, 1'b1, 8'hF0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F},
        {16'hC000, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00},
        {16'hC001, 1'b0, 1'b0, 8'hA7, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
        {16'hC002, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00},
        {16'hBFFF, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
        {16'h4000, 1'b1, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00},
        {16'hC003, 1'b0, 1'b1, 8'h33, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
        {16'hC000, 1'b0, 1'b1, 8'hA7, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE5}
    };
    string row_req [NV] = '{"R3", "R2", "R4", "R4", "R5", "R5",
                            "R2", "R2", "R2", "R2", "R4"};

    // Compare one value and log a failure line
    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one bus sample at a falling edge
    task automatic drive(input logic [15:0] a, input logic rw, input logic ph,
                         input logic [7:0] wd, input logic [7:0] rd);
        cpu_addr  = a;
        cpu_rw    = rw;
        cpu_phi2  = ph;
        cpu_wdata = wd;
        dev_rdata = rd;
    endtask

    // Watchdog: a hung run still reaches the summary as a failure
    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset holds outputs idle even with a decoded write pending
        @(negedge clk);
        drive(16'hC001, 1'b0, 1'b1, 8'h81, 8'hFF);
        @(negedge clk);
        @(negedge clk);
        chk("R1", "rd_n", dev_rd_n, 1);
        chk("R1", "wr_n", dev_wr_n, 1);
        chk("R1", "mode", dev_mode, 0);
        chk("R1", "oe", cpu_rdata_oe, 0);
        chk("R1", "dev_wdata", dev_wdata, 0);
        rst_n = 1'b1;

        // Table walk: drive at one falling edge, check at the next
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][53:38], VEC[i][37], VEC[i][36], VEC[i][35:28], VEC[i][27:20]);
            @(negedge clk);
            chk(row_req[i], "rd_n", dev_rd_n, VEC[i][19]);
            chk(row_req[i], "wr_n", dev_wr_n, VEC[i][18]);
            chk("R6", "both low", (!dev_rd_n && !dev_wr_n), 0);
            chk("R7", "mode", dev_mode, VEC[i][17]);
            chk("R9", "oe", cpu_rdata_oe, VEC[i][16]);
            chk("R9", "cpu_rdata", cpu_rdata, VEC[i][15:8]);
            chk("R8", "dev_wdata", dev_wdata, VEC[i][7:0]);
        end

        // R9: read data follows the device within the same cycle of a read
        drive(16'hC001, 1'b1, 1'b1, 8'h00, 8'h01);
        @(negedge clk);
        chk("R9", "rdata first", cpu_rdata, 16'h80);
        dev_rdata = 8'h12;
        #1;
        chk("R9", "rdata changed", cpu_rdata, 16'h48);

        // R5: dropping Phi2 mid-access releases the strobe and the bus
        cpu_phi2 = 1'b0;
        @(negedge clk);
        chk("R5", "rd_n after phi1", dev_rd_n, 1);
        chk("R9", "oe after phi1", cpu_rdata_oe, 0);
        chk("R9", "rdata after phi1", cpu_rdata, 0);

        // R1: reset in the middle of a write clears strobe, mode and data
        drive(16'hC001, 1'b0, 1'b1, 8'h0F, 8'h00);
        @(negedge clk);
        chk("R4", "wr_n before reset", dev_wr_n, 0);
        chk("R8", "wdata before reset", dev_wdata, 16'hF0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "wr_n in reset", dev_wr_n, 1);
        chk("R1", "mode in reset", dev_mode, 0);
        chk("R1", "wdata in reset", dev_wdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4", "wr_n after reset", dev_wr_n, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule